// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words from a three-wire serial port (serial clock, serial data, latch strobe) and stores each word in one of four control latches. While the strobe is low, each rising edge of the serial clock shifts one data bit into a 24-bit word register, with the most significant bit first. When the strobe rises, the two lowest bits of the word register (the last two bits shifted in) select a destination. The remaining 22 bits are copied into that latch. Every latch drives its contents onto its own parallel output.

The serial pins are assumed to be already synchronous to the system clock `clk_i`. The block finds the edges of the serial clock and of the strobe by comparing each pin with its value one system clock earlier. Destination code 3 loads an initialization latch and, with the same write, the function latch. For that code it also raises a counter-reset output for exactly one system clock.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_ni` is low, all four latch outputs, the word register and `cnt_rst_o` are zero.
- R2: With `sle_i` low, a rising edge of `sclk_i` shifts `sdata_i` into bit 0 of the word register, and the older bits move up one place. The first bit sent ends up in bit 23.
- R3: With `sle_i` high, edges of `sclk_i` leave the word register unchanged. A later strobe therefore loads the word that was present before `sle_i` went high.
- R4: When `sle_i` rises and word bits [1:0] are 2'b00, `ref_latch_o` takes word bits [23:2] and the other latches hold their values.
- R5: Code 2'b01 loads `cnt_latch_o` with word bits [23:2]. The other latches hold their values.
- R6: Code 2'b10 loads `func_latch_o` with word bits [23:2]. The other latches hold their values.
- R7: Code 2'b11 loads both `init_latch_o` and `func_latch_o` with word bits [23:2]. It also drives `cnt_rst_o` high for the one system clock after the edge on which the strobe rise is seen.
- R8: `cnt_rst_o` is never high for longer than one cycle, and codes 2'b00, 2'b01 and 2'b10 never raise it.
- R9: A latch output changes only in the cycle after a rising edge of `sle_i` is seen. Serial shifting without a strobe leaves every latch unchanged.
- R10: If more than 24 bits are shifted in before a strobe, only the last 24 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock (synchronous to clk_i) |
| sdata_i | input | 1 | Serial data, MSB first |
| sle_i | input | 1 | Latch strobe; its rising edge loads a latch |
| ref_latch_o | output | 22 | Reference divider latch (code 00) |
| cnt_latch_o | output | 22 | Divider counter latch (code 01) |
| func_latch_o | output | 22 | Function latch (codes 10 and 11) |
| init_latch_o | output | 22 | Initialization latch (code 11) |
| cnt_rst_o | output | 1 | One-cycle counter reset pulse on code 11 |

## Verification
On every cycle, the assertions check the following:
- which bit enters the word register on each serial edge;
- that the word register is frozen while the strobe is high;
- that a latch output changes only after a strobe edge;
- that the counter-reset pulse lasts one cycle and comes only from code 11, with the function and initialization latches equal at that moment.

Only the bench scenarios can show that the payload reaches the right latch for each code, in the right bit order. The same holds for the 28-bit over-length word and for bits clocked while the strobe is high being discarded before a later strobe.

// File: rtl/serial_cfg_loader_pkg.sv
package serial_cfg_loader_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned PAY_W  = WORD_W - SEL_W;
  localparam int unsigned N_DST  = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    DST_REF  = 2'd0,
    DST_CNT  = 2'd1,
    DST_FUNC = 2'd2,
    DST_INIT = 2'd3
  } dst_e;
endpackage

// File: rtl/scl_edge_det.sv
module scl_edge_det #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  // reset to ones: a pin already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= sig_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_rise
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/scl_shift_reg.sv
module scl_shift_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (shift_en_i) word_q <= {word_q[W-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/scl_dest_bank.sv
module scl_dest_bank
  import serial_cfg_loader_pkg::*;
#(
  parameter int unsigned PW = PAY_W,
  parameter int unsigned SW = SEL_W,
  parameter int unsigned ND = N_DST
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  strobe_i,
  input  logic [SW-1:0]         sel_i,
  input  logic [PW-1:0]         pay_i,
  output logic [ND-1:0][PW-1:0] lat_o,
  output logic                  cnt_rst_o
);
  logic [ND-1:0] wr_en;
  logic          pulse_q;

  for (genvar d = 0; d < ND; d++) begin : g_dst
    logic [PW-1:0] lat_q;
    logic          hit;
    // init code mirrors into the function latch
    if (d == int'(DST_FUNC)) begin : g_mirror
      assign hit = (sel_i == SW'(d)) || (sel_i == SW'(DST_INIT));
    end else begin : g_plain
      assign hit = (sel_i == SW'(d));
    end
    assign wr_en[d] = strobe_i & hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_q <= '0;
      else if (wr_en[d]) lat_q <= pay_i;
    end
    assign lat_o[d] = lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= strobe_i && (sel_i == SW'(DST_INIT));
  end

  assign cnt_rst_o = pulse_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_loader_pkg::*;
#(
  parameter int unsigned WW = WORD_W,
  parameter int unsigned SW = SEL_W,
  localparam int unsigned PW = WW - SW,
  localparam int unsigned ND = 1 << SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          sle_i,
  output logic [PW-1:0] ref_latch_o,
  output logic [PW-1:0] cnt_latch_o,
  output logic [PW-1:0] func_latch_o,
  output logic [PW-1:0] init_latch_o,
  output logic          cnt_rst_o
);
  logic [1:0]                 rise;
  logic                       sclk_rise, le_rise;
  logic [WW-1:0]              word_q;
  logic [ND-1:0][PW-1:0]      lat;

  scl_edge_det #(.N(2)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({sle_i, sclk_i}),
    .rise_o (rise)
  );
  assign sclk_rise = rise[0];
  assign le_rise   = rise[1];

  scl_shift_reg #(.W(WW)) i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (sclk_rise & ~sle_i),
    .bit_i      (sdata_i),
    .word_o     (word_q)
  );

  scl_dest_bank #(.PW(PW), .SW(SW), .ND(ND)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (le_rise),
    .sel_i     (word_q[SW-1:0]),
    .pay_i     (word_q[WW-1:SW]),
    .lat_o     (lat),
    .cnt_rst_o (cnt_rst_o)
  );

  assign ref_latch_o  = lat[DST_REF];
  assign cnt_latch_o  = lat[DST_CNT];
  assign func_latch_o = lat[DST_FUNC];
  assign init_latch_o = lat[DST_INIT];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
  parameter int unsigned WW = 24,
  parameter int unsigned PW = 22
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sclk_i,
  input logic          sdata_i,
  input logic          sle_i,
  input logic [WW-1:0] word_q,
  input logic [PW-1:0] ref_latch_o,
  input logic [PW-1:0] cnt_latch_o,
  input logic [PW-1:0] func_latch_o,
  input logic [PW-1:0] init_latch_o,
  input logic          cnt_rst_o
);
  logic sclk_prev, le_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b1;
      le_prev   <= 1'b1;
    end else begin
      sclk_prev <= sclk_i;
      le_prev   <= sle_i;
    end
  end

  logic shift_c, strobe_c;
  logic [3*PW+PW-1:0] all_lat;
  assign shift_c  = sclk_i & ~sclk_prev & ~sle_i;
  assign strobe_c = sle_i & ~le_prev;
  assign all_lat  = {ref_latch_o, cnt_latch_o, func_latch_o, init_latch_o};

  AST_SHIFT_IN_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_c |=> word_q[0] == $past(sdata_i)); // R2
  AST_FROZEN_LE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sle_i |=> $stable(word_q)); // R3
  AST_LATCH_ONLY_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(all_lat) |-> $past(strobe_c)); // R9
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |=> !cnt_rst_o); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |-> $past(strobe_c) && $past(word_q[1:0]) == 2'b11); // R7
  AST_INIT_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst_o |-> func_latch_o == init_latch_o); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> all_lat == '0 && !cnt_rst_o); // R1
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.WW(WW), .PW(PW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sclk_i       (sclk_i),
  .sdata_i      (sdata_i),
  .sle_i        (sle_i),
  .word_q       (word_q),
  .ref_latch_o  (ref_latch_o),
  .cnt_latch_o  (cnt_latch_o),
  .func_latch_o (func_latch_o),
  .init_latch_o (init_latch_o),
  .cnt_rst_o    (cnt_rst_o)
);

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, sle_i = 1'b0;
  logic [21:0] ref_latch_o, cnt_latch_o, func_latch_o, init_latch_o;
  logic cnt_rst_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #10 clk_i = ~clk_i;

  serial_cfg_loader i_serial_cfg_loader (.*);

  // behavioural reference model
  bit          q[$];
  logic [21:0] m_lat[4];
  logic        m_pulse, m_sclk_prev, m_le_prev;

  function automatic logic [23:0] m_word();
    logic [23:0] w = '0;
    foreach (q[i]) w = {w[22:0], q[i]};
    return w;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      foreach (m_lat[i]) m_lat[i] = '0;
      m_pulse = 0; m_sclk_prev = 1; m_le_prev = 1;
    end else begin
      logic [23:0] w;
      w = m_word();
      m_pulse = 0;
      if (sle_i && !m_le_prev) begin
        m_lat[w[1:0]] = w[23:2];
        if (w[1:0] == 2'd3) begin m_lat[2] = w[23:2]; m_pulse = 1; end
      end
      if (sclk_i && !m_sclk_prev && !sle_i) begin
        q.push_back(sdata_i);
        if (q.size() > 24) void'(q.pop_front());
      end
      m_le_prev = sle_i; m_sclk_prev = sclk_i;
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    chk(ref_latch_o == m_lat[0], "R4 model ref", ref_latch_o, m_lat[0]);
    chk(cnt_latch_o == m_lat[1], "R5 model cnt", cnt_latch_o, m_lat[1]);
    chk(func_latch_o == m_lat[2], "R6 model func", func_latch_o, m_lat[2]);
    chk(init_latch_o == m_lat[3], "R7 model init", init_latch_o, m_lat[3]);
    chk(cnt_rst_o == m_pulse, "R8 model pulse", cnt_rst_o, m_pulse);
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      summary();
    end
  end

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk_i); sdata_i = v[i]; sclk_i = 0;
      @(negedge clk_i);
      @(negedge clk_i); sclk_i = 1;
      @(negedge clk_i);
    end
    @(negedge clk_i); sclk_i = 0;
  endtask

  task automatic strobe(output logic p1, output logic p2);
    @(negedge clk_i); sle_i = 1;
    @(negedge clk_i); p1 = cnt_rst_o;
    @(negedge clk_i); p2 = cnt_rst_o; sle_i = 0;
    @(negedge clk_i);
  endtask

  initial begin
    logic p1, p2;
    repeat (3) @(negedge clk_i);
    chk({ref_latch_o, cnt_latch_o, func_latch_o, init_latch_o} == '0, "R1 reset latches",
        ref_latch_o, 0);
    chk(cnt_rst_o == 0, "R1 reset pulse", cnt_rst_o, 0);
    rst_ni = 1;

    send_bits({22'h2AAA55, 2'b00}, 24); strobe(p1, p2);
    chk(ref_latch_o == 22'h2AAA55, "R4 ref load", ref_latch_o, 22'h2AAA55);
    chk(cnt_latch_o == 0 && func_latch_o == 0, "R4 others held", cnt_latch_o, 0);
    chk(p1 == 0, "R8 no pulse code 00", p1, 0);

    send_bits({22'h012345, 2'b01}, 24); strobe(p1, p2);
    chk(cnt_latch_o == 22'h012345, "R5 cnt load", cnt_latch_o, 22'h012345);
    chk(ref_latch_o == 22'h2AAA55, "R5 ref held", ref_latch_o, 22'h2AAA55);
    chk(p1 == 0, "R8 no pulse code 01", p1, 0);

    // MSB-first: asymmetric pattern distinguishes bit order
    send_bits({22'h300001, 2'b10}, 24); strobe(p1, p2);
    chk(func_latch_o == 22'h300001, "R2 R6 func load order", func_latch_o, 22'h300001);
    chk(init_latch_o == 0, "R6 init held", init_latch_o, 0);
    chk(p1 == 0, "R8 no pulse code 10", p1, 0);

    send_bits({22'h1BEEF7, 2'b11}, 24); strobe(p1, p2);
    chk(init_latch_o == 22'h1BEEF7, "R7 init load", init_latch_o, 22'h1BEEF7);
    chk(func_latch_o == 22'h1BEEF7, "R7 func mirror", func_latch_o, 22'h1BEEF7);
    chk(p1 == 1, "R7 pulse high", p1, 1);
    chk(p2 == 0, "R8 pulse one cycle", p2, 0);

    // shifting without strobe leaves latches
    send_bits({22'h3FFFFF, 2'b00}, 24);
    chk(ref_latch_o == 22'h2AAA55, "R9 no strobe no change", ref_latch_o, 22'h2AAA55);

    // over-length word: 4 extra leading bits dropped
    send_bits({4'hF, 22'h0ABCDE, 2'b01}, 28); strobe(p1, p2);
    chk(cnt_latch_o == 22'h0ABCDE, "R10 last 24 kept", cnt_latch_o, 22'h0ABCDE);

    // bits clocked while strobe high are ignored
    send_bits({22'h155555, 2'b00}, 24); strobe(p1, p2);
    @(negedge clk_i); sle_i = 1;
    send_bits({22'h2F0F0F, 2'b00}, 24);
    @(negedge clk_i); sle_i = 0;
    @(negedge clk_i); sle_i = 1;
    @(negedge clk_i); sle_i = 1;
    @(negedge clk_i); sle_i = 0;
    chk(ref_latch_o == 22'h155555, "R3 le-high shifts ignored", ref_latch_o, 22'h155555);

    repeat (4) @(negedge clk_i);
    summary();
  end
endmodule